// File: doc/BRIEF.md
# Fast Fault Shutdown Controller

This block decides, cycle by cycle, whether the gate outputs of a half-bridge driver may switch. The driver shares one shutdown line with an outside controller and an RC timing network. The block sees that line only as two digitized flags: one says the line is below the lower threshold, the other says it is above the upper threshold. It also receives the digital trip from an overcurrent comparator and a supply-good flag from the undervoltage monitor. It drives a gate enable and the control for an open-drain pull-down on the shared line.

A trip drops the enable at once, without waiting for the line to fall. The block then pulls the line low until the lower threshold is seen, and releases it so the external pull-up can recharge the capacitor. The enable comes back only after the line has been seen above the upper threshold. A low level that outside logic drives onto the line is not latched. It gates the outputs only for as long as it lasts, so the line can be used for PWM chopping. A sticky status bit records every trip until software clears it by writing a one.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: While `supply_ok_i` is 1, a high `trip_i` forces `gate_en_o` to 0 in the same cycle, whatever the line flags show.
- R2: A trip with the supply good sets `od_pull_o` to 1 in the same cycle. The pull-down then stays on in every later cycle until `line_lo_i` is sampled at 1.
- R3: Once `line_lo_i` is sampled at 1 while the pull-down is on and no trip is present, `od_pull_o` is 0 from the next cycle.
- R4: After a fault, `gate_en_o` returns to 1 only in the cycle after `line_hi_i` is sampled at 1. Until then it stays 0.
- R5: When `line_lo_i` is 1 and no trip is present, `gate_en_o` is 0 in that same cycle. `od_pull_o` and `fault_sticky_o` are not touched. The enable returns one cycle after `line_hi_i` is sampled, with no lockout period.
- R6: While `supply_ok_i` is 0, `gate_en_o` is 0 and `trip_i` has no effect: it neither turns on `od_pull_o` nor sets `fault_sticky_o`.
- R7: While both line flags are 0, the line keeps the state it last had. It does not re-enable a line that was last seen low.
- R8: A trip that arrives while the pull-down is on, or while the block waits for the line to rise, restarts the pull-down. A trip that coincides with `line_lo_i` keeps the pull-down on.
- R9: `fault_sticky_o` is 1 from the cycle after any trip taken with the supply good. A 1 on `fault_clr_i` clears it at the next edge. If a trip and a clear arrive in the same cycle, the trip wins.
- R10: After synchronous reset (`rst` = 1), `gate_en_o`, `od_pull_o` and `fault_sticky_o` are all 0. `gate_en_o` stays 0 until `line_hi_i` has been sampled at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_i | input | 1 | Overcurrent comparator trip, active high |
| line_lo_i | input | 1 | Shared line is below the lower threshold |
| line_hi_i | input | 1 | Shared line is above the upper threshold |
| supply_ok_i | input | 1 | Supply is out of undervoltage lockout |
| fault_clr_i | input | 1 | Write-one-to-clear for the sticky fault bit |
| gate_en_o | output | 1 | Gate outputs may follow their commands |
| od_pull_o | output | 1 | Open-drain pull-down on the shared line |
| fault_sticky_o | output | 1 | A trip has been taken since the last clear |

## Verification
The results fall into two groups by timing. The enable drop on a trip, on a low line or on a supply loss is combinational, and so is the pull-down turn-on. These are due in the same cycle as the stimulus. The pull-down release, the enable restore and the sticky bit each pass through one register, so they are due one edge after the flag that causes them is sampled. The bench changes inputs just after a falling edge. It checks the same-cycle results a moment later in that low phase, and checks the registered results at the next falling edge. In the cycles between a stimulus and its due result, it also checks that the result has not arrived early.

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic line_lo_i,
  input  logic line_hi_i,
  input  logic supply_ok_i,
  input  logic fault_clr_i,
  output logic gate_en_o,
  output logic od_pull_o,
  output logic fault_sticky_o
);

  typedef enum logic [1:0] {IDLE = 2'd0, FAULT_PULL = 2'd1, WAIT_RISE = 2'd2} st_e;

  st_e  st_q, st_d;
  logic line_up_q;
  logic trip_live;

  assign trip_live = trip_i & supply_ok_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      IDLE:       if (trip_live) st_d = FAULT_PULL;
      FAULT_PULL: if (!trip_live && line_lo_i) st_d = WAIT_RISE;
      WAIT_RISE:  if (trip_live) st_d = FAULT_PULL;
                  else if (line_hi_i) st_d = IDLE;
      default:    st_d = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= IDLE;
      line_up_q      <= 1'b0;
      fault_sticky_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (line_lo_i)      line_up_q <= 1'b0;
      else if (line_hi_i) line_up_q <= 1'b1;
      if (trip_live)        fault_sticky_o <= 1'b1;
      else if (fault_clr_i) fault_sticky_o <= 1'b0;
    end
  end

  assign od_pull_o = trip_live | (st_q == FAULT_PULL);
  assign gate_en_o = supply_ok_i & ~trip_live & ~line_lo_i & line_up_q & (st_q == IDLE);

  assert_trip_kills_enable_R1: assert property (@(posedge clk) disable iff (rst)
    (trip_i && supply_ok_i) |-> !gate_en_o);

  assert_pull_held_R2: assert property (@(posedge clk) disable iff (rst)
    (od_pull_o && !line_lo_i) |=> od_pull_o);

  assert_pull_release_R3: assert property (@(posedge clk) disable iff (rst)
    (od_pull_o && line_lo_i && !(trip_i && supply_ok_i))
      |=> (!od_pull_o || (trip_i && supply_ok_i)));

  assert_enable_needs_high_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_en_o) && $past(supply_ok_i)) |-> $past(line_hi_i));

  assert_low_line_gates_R5: assert property (@(posedge clk) disable iff (rst)
    line_lo_i |-> !gate_en_o);

  assert_lockout_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok_i && !fault_sticky_o) |=> !fault_sticky_o);

  assert_lockout_disable_R6: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |-> !gate_en_o);

  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
    (trip_i && supply_ok_i) |=> fault_sticky_o);

  assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (fault_clr_i && !(trip_i && supply_ok_i)) |=> !fault_sticky_o);

endmodule

// File: tb/fault_shutdown_ctrl_tb.sv
module fault_shutdown_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, trip, lo, hi, ok, clr;
  logic en, pd, sticky;
  int   n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_shutdown_ctrl dut_i (
    .clk(clk), .rst(rst), .trip_i(trip), .line_lo_i(lo), .line_hi_i(hi),
    .supply_ok_i(ok), .fault_clr_i(clr),
    .gate_en_o(en), .od_pull_o(pd), .fault_sticky_o(sticky));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic line_rise();
    lo = 0; hi = 1; settle();
    chk(en, 1'b0, "R4 enable early");
    tick();
    chk(en, 1'b1, "R4 enable restored");
  endtask

  task automatic t_reset();
    rst = 1; trip = 0; lo = 0; hi = 0; ok = 1; clr = 0;
    repeat (3) tick();
    rst = 0; settle();
    chk(en, 1'b0, "R10 enable after reset");
    chk(pd, 1'b0, "R10 pull after reset");
    chk(sticky, 1'b0, "R10 sticky after reset");
    repeat (3) tick();
    chk(en, 1'b0, "R10 enable before first high");
    line_rise();
  endtask

  task automatic t_trip();
    trip = 1; settle();
    chk(en, 1'b0, "R1 same-cycle disable");
    chk(pd, 1'b1, "R2 same-cycle pull");
    tick();
    trip = 0; hi = 0; settle();
    chk(pd, 1'b1, "R2 pull held");
    chk(sticky, 1'b1, "R9 sticky set");
    chk(en, 1'b0, "R1 disabled after trip");
    repeat (3) tick();
    chk(pd, 1'b1, "R2 pull held mid-line");
    lo = 1; settle();
    chk(pd, 1'b1, "R3 release not early");
    tick();
    chk(pd, 1'b0, "R3 pull released");
    lo = 0;
    repeat (3) tick();
    chk(en, 1'b0, "R7 hysteresis holds low");
    line_rise();
  endtask

  task automatic t_retrigger();
    trip = 1; tick(); trip = 0; hi = 0;
    lo = 1; tick(); lo = 0; settle();
    chk(pd, 1'b0, "R8 waiting for rise");
    trip = 1; settle();
    chk(pd, 1'b1, "R8 trip in wait pulls");
    tick(); trip = 0; settle();
    chk(pd, 1'b1, "R8 pull restarted");
    trip = 1; lo = 1; tick(); trip = 0; settle();
    chk(pd, 1'b1, "R8 trip beats low line");
    tick();
    chk(pd, 1'b0, "R3 release after retrigger");
    line_rise();
  endtask

  task automatic t_sticky();
    trip = 1; clr = 1; tick(); trip = 0; clr = 0; hi = 0; settle();
    chk(sticky, 1'b1, "R9 set wins over clear");
    lo = 1; tick();
    line_rise();
    clr = 1; tick(); clr = 0; settle();
    chk(sticky, 1'b0, "R9 cleared");
  endtask

  task automatic t_chop();
    for (int k = 0; k < 3; k++) begin
      hi = 0; lo = 1; settle();
      chk(en, 1'b0, "R5 chop disables same cycle");
      chk(pd, 1'b0, "R5 no pull on external low");
      tick();
      chk(sticky, 1'b0, "R5 no fault recorded");
      line_rise();
    end
  endtask

  task automatic t_lockout();
    ok = 0; settle();
    chk(en, 1'b0, "R6 lockout disables");
    trip = 1; settle();
    chk(pd, 1'b0, "R6 trip ignored pull");
    tick();
    chk(sticky, 1'b0, "R6 trip ignored sticky");
    chk(pd, 1'b0, "R6 no pull after edge");
    trip = 0; ok = 1; tick();
    chk(en, 1'b1, "R6 enable after lockout");
  endtask

  initial begin
    t_reset();
    t_trip();
    t_retrigger();
    t_sticky();
    t_chop();
    t_lockout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule